// File: doc/BRIEF.md
# Dual-Bank Flash Command Interpreter

This block sits behind the bus of a two-bank NOR-style flash and turns 16-bit bus writes into command decisions. The low byte of every write is a command code. Each bank keeps its own read mode (array, status, identifier or query), its own pending two-cycle sequence, its own sticky error bits and its own write-engine stub. A write or read reaches bank 1 when its address is at or above `BANK_BOUNDARY`, and bank 0 otherwise. So one bank can keep returning array data while the other is programming or erasing.

The write-engine stub is a cycle counter with a start, hold, busy and done handshake. It models the duration of a program or erase, and it can be frozen by a suspend and released by a resume. The cell array is not modelled. In its place each bank holds one placeholder word. Erasing sets that word to all ones, programming ANDs the data word into it, and array reads return it. Identifier and query reads return parameter values.

A read request returns its data through a register one cycle later. The data reflects the mode and status that held before any write in the same cycle.

Top module: `flash_cmd_top`

## Requirements
- R1: While `rst_n` is low, `rvalid` is 0. After reset, both banks are idle, in array mode, with no sticky bits set, and an array read returns 16'hFFFF.
- R2: Command 70h puts the addressed bank in status mode. A status read returns 8'h00 in bits 15:8 and the status byte in bits 7:0. The status byte is laid out as follows: bit 7 = engine ready, bit 6 = erase suspended, bit 5 = erase error, bit 4 = program error, bit 3 = voltage error, bit 2 = program suspended, bits 1:0 = 0. An address at or above `BANK_BOUNDARY` selects bank 1.
- R3: Command 40h or 10h followed by a data write starts a program when the bank is idle. The bank enters status mode and ANDs the data into its placeholder word. Ready reads 0 until the engine finishes on the `PROG_CYCLES`-th clock edge after the start edge.
- R4: Command 20h followed by D0h starts an erase. The bank enters status mode and its placeholder word becomes all ones. The erase finishes on the `ERASE_CYCLES`-th edge after the start.
- R5: Command 20h followed by any code other than D0h starts nothing. It sets the program-error and erase-error bits and puts the bank in status mode.
- R6: While a bank's engine is running, writes to that bank other than B0h and 70h have no effect. This includes FFh, 90h and 50h.
- R7: B0h to a running bank freezes the engine count and sets ready. It also sets program-suspended for a program or erase-suspended for an erase, and puts the bank in status mode.
- R8: D0h to a suspended bank clears the suspended bit and ready. The engine then runs the cycles it still had left.
- R9: The voltage-error, program-error and erase-error bits stay set across all commands until 50h. Command 50h clears them and returns the bank to array mode.
- R10: If `vpp_ok` is low on the write that would start a program or erase, no engine starts, the voltage-error bit is set, and the bank enters status mode.
- R11: Each bank keeps its own mode. The idle bank reads and changes modes while the other bank runs, and FFh to the busy bank only takes effect once it is idle.
- R12: Command 90h sets identifier mode: `addr[0]`=0 reads `MFG_ID` and 1 reads `DEV_ID`, in bits 7:0 with zero above. Command 98h sets query mode, which reads `QUERY_FILL`.
- R13: After 60h, a following 01h, 2Fh or D0h is accepted with no change to mode or status. Any other code sets program-error and erase-error and selects status mode.
- R14: `rvalid` is 1 exactly in the cycle after a cycle with `rd_en` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | ADDR_W | Word address; selects bank and identifier word |
| wdata | input | DW | Write data; command code in bits 7:0 |
| vpp_ok | input | 1 | Programming voltage is valid |
| rdata | output | DW | Read data, registered |
| rvalid | output | 1 | Read data valid, one cycle after `rd_en` |

## Verification
Read data is due one cycle after `rd_en`. A command written in cycle N therefore shows in data read in cycle N+1 and returned in cycle N+2. An engine started at edge E reports ready again in a read issued after edge E+`PROG_CYCLES` (or E+`ERASE_CYCLES`), with suspended cycles added. The bench drives inputs on the falling edge and advances a behavioural per-bank model by one edge. It then compares `rvalid` and `rdata` on the next falling edge in every cycle, so each result is checked in exactly the cycle it is due. Suspend and resume are placed well away from the engine's final edge.

// File: rtl/flcmd_pkg.sv
package flcmd_pkg;
    typedef enum logic [1:0] {MD_ARRAY, MD_STATUS, MD_IDENT, MD_QUERY} rmode_e;
    typedef enum logic [1:0] {PD_NONE, PD_PROG, PD_ERASE, PD_PROT} pend_e;
    typedef enum logic [2:0] {OP_IDLE, OP_PROG, OP_ERASE, OP_PSUSP, OP_ESUSP} op_e;

    localparam logic [7:0] C_PROG     = 8'h40;
    localparam logic [7:0] C_PROG_ALT = 8'h10;
    localparam logic [7:0] C_ERASE    = 8'h20;
    localparam logic [7:0] C_CLEAR    = 8'h50;
    localparam logic [7:0] C_PROT     = 8'h60;
    localparam logic [7:0] C_RSTAT    = 8'h70;
    localparam logic [7:0] C_IDENT    = 8'h90;
    localparam logic [7:0] C_QUERY    = 8'h98;
    localparam logic [7:0] C_SUSP     = 8'hB0;
    localparam logic [7:0] C_CONF     = 8'hD0;
    localparam logic [7:0] C_ARRAY    = 8'hFF;
    localparam logic [7:0] C_LOCK     = 8'h01;
    localparam logic [7:0] C_LOCKDN   = 8'h2F;

    typedef struct packed {
        rmode_e mode;
        pend_e  pend;
        op_e    op;
        logic   volt_err;
        logic   prog_err;
        logic   erase_err;
    } bank_st_t;
endpackage

// File: rtl/flcmd_engine.sv
module flcmd_engine #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    input  logic          hold,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = load;
        end else if (cnt_q != '0 && !hold) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    assign busy = (cnt_q != '0);
    assign done = !start && !hold && (cnt_q == CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R8
    frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !start) |=> $stable(cnt_q));
endmodule

// File: rtl/flcmd_bank.sv
module flcmd_bank
    import flcmd_pkg::*;
#(
    parameter int unsigned DW           = 16,
    parameter int unsigned PROG_CYCLES  = 8,
    parameter int unsigned ERASE_CYCLES = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdata,
    input  logic          vpp_ok,
    output rmode_e        mode,
    output logic [7:0]    status,
    output logic [DW-1:0] word
);
    localparam int unsigned MAXC = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] LD_PROG  = CW'(PROG_CYCLES);
    localparam logic [CW-1:0] LD_ERASE = CW'(ERASE_CYCLES);

    bank_st_t      s_d, s_q;
    logic [DW-1:0] word_d, word_q;
    logic [7:0]    cmd;
    logic          running, eng_hold, eng_start, eng_busy, eng_done;
    logic [CW-1:0] eng_load;

    assign cmd      = wdata[7:0];
    assign running  = (s_q.op == OP_PROG) || (s_q.op == OP_ERASE);
    assign eng_hold = (s_q.op == OP_PSUSP) || (s_q.op == OP_ESUSP);

    always_comb begin
        s_d       = s_q;
        word_d    = word_q;
        eng_start = 1'b0;
        eng_load  = LD_PROG;
        if (eng_done) s_d.op = OP_IDLE;
        if (wr) begin
            if (running) begin
                if (!eng_done) begin
                    if (cmd == C_SUSP) begin
                        s_d.op   = (s_q.op == OP_PROG) ? OP_PSUSP : OP_ESUSP;
                        s_d.mode = MD_STATUS;
                    end else if (cmd == C_RSTAT) begin
                        s_d.mode = MD_STATUS;
                    end
                end
            end else if (s_q.pend == PD_PROG) begin
                s_d.pend = PD_NONE;
                s_d.mode = MD_STATUS;
                if (vpp_ok) begin
                    eng_start = 1'b1;
                    s_d.op    = OP_PROG;
                    word_d    = word_q & wdata;
                end else begin
                    s_d.volt_err = 1'b1;
                end
            end else if (s_q.pend == PD_ERASE) begin
                s_d.pend = PD_NONE;
                s_d.mode = MD_STATUS;
                if (cmd == C_CONF) begin
                    if (vpp_ok) begin
                        eng_start = 1'b1;
                        eng_load  = LD_ERASE;
                        s_d.op    = OP_ERASE;
                        word_d    = '1;
                    end else begin
                        s_d.volt_err = 1'b1;
                    end
                end else begin
                    s_d.prog_err  = 1'b1;
                    s_d.erase_err = 1'b1;
                end
            end else if (s_q.pend == PD_PROT) begin
                s_d.pend = PD_NONE;
                if (!(cmd == C_LOCK || cmd == C_LOCKDN || cmd == C_CONF)) begin
                    s_d.prog_err  = 1'b1;
                    s_d.erase_err = 1'b1;
                    s_d.mode      = MD_STATUS;
                end
            end else begin
                case (cmd)
                    C_PROG, C_PROG_ALT: if (s_q.op == OP_IDLE) s_d.pend = PD_PROG;
                    C_ERASE:            if (s_q.op == OP_IDLE) s_d.pend = PD_ERASE;
                    C_CLEAR: begin
                        s_d.volt_err  = 1'b0;
                        s_d.prog_err  = 1'b0;
                        s_d.erase_err = 1'b0;
                        s_d.mode      = MD_ARRAY;
                    end
                    C_PROT:  s_d.pend = PD_PROT;
                    C_RSTAT: s_d.mode = MD_STATUS;
                    C_IDENT: s_d.mode = MD_IDENT;
                    C_QUERY: s_d.mode = MD_QUERY;
                    C_ARRAY: s_d.mode = MD_ARRAY;
                    C_CONF: begin
                        if (eng_hold) begin
                            s_d.op   = (s_q.op == OP_PSUSP) ? OP_PROG : OP_ERASE;
                            s_d.mode = MD_STATUS;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '{mode: MD_ARRAY, pend: PD_NONE, op: OP_IDLE,
                        volt_err: 1'b0, prog_err: 1'b0, erase_err: 1'b0};
            word_q <= '1;
        end else begin
            s_q    <= s_d;
            word_q <= word_d;
        end
    end

    flcmd_engine #(.CW(CW)) u_eng (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .load  (eng_load),
        .hold  (eng_hold),
        .busy  (eng_busy),
        .done  (eng_done)
    );

    assign mode   = s_q.mode;
    assign word   = word_q;
    assign status = {!running, s_q.op == OP_ESUSP, s_q.erase_err, s_q.prog_err,
                     s_q.volt_err, s_q.op == OP_PSUSP, 2'b00};

    // R3
    eng_busy_when_running_chk: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> eng_busy);
    // R1
    idle_engine_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.op == OP_IDLE) |-> !eng_busy);
    // R10
    no_start_without_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> vpp_ok);
    // R9
    sticky_prog_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.prog_err && !(wr && cmd == C_CLEAR)) |=> s_q.prog_err);
endmodule

// File: rtl/flash_cmd_top.sv
module flash_cmd_top
    import flcmd_pkg::*;
#(
    parameter int unsigned       ADDR_W        = 21,
    parameter int unsigned       DW            = 16,
    parameter int unsigned       PROG_CYCLES   = 8,
    parameter int unsigned       ERASE_CYCLES  = 20,
    parameter logic [ADDR_W-1:0] BANK_BOUNDARY = 21'h040000,
    parameter logic [7:0]        MFG_ID        = 8'hA5,
    parameter logic [7:0]        DEV_ID        = 8'h5A,
    parameter logic [DW-1:0]     QUERY_FILL    = 16'h00C3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DW-1:0]     wdata,
    input  logic              vpp_ok,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    localparam int unsigned NB = 2;

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } rd_st_t;

    rd_st_t        rd_d, rd_q;
    logic          sel;
    rmode_e        bmode [NB];
    logic [7:0]    bstat [NB];
    logic [DW-1:0] bword [NB];

    assign sel = (addr >= BANK_BOUNDARY);

    for (genvar g = 0; g < NB; g++) begin : g_bank
        flcmd_bank #(
            .DW           (DW),
            .PROG_CYCLES  (PROG_CYCLES),
            .ERASE_CYCLES (ERASE_CYCLES)
        ) u_bank (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr     (wr_en && (sel == g[0])),
            .wdata  (wdata),
            .vpp_ok (vpp_ok),
            .mode   (bmode[g]),
            .status (bstat[g]),
            .word   (bword[g])
        );
    end

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = rd_q.data;
        if (rd_en) begin
            case (bmode[sel])
                MD_ARRAY:  rd_d.data = bword[sel];
                MD_STATUS: rd_d.data = {{(DW-8){1'b0}}, bstat[sel]};
                MD_IDENT:  rd_d.data = {{(DW-8){1'b0}}, addr[0] ? DEV_ID : MFG_ID};
                default:   rd_d.data = QUERY_FILL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rdata  = rd_q.data;
    assign rvalid = rd_q.valid;

    // R14
    read_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    // R14
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
endmodule

// File: tb/tb_flash_cmd_top.sv
`timescale 1ns/1ps
module tb_flash_cmd_top;
    localparam int          PC    = 8;
    localparam int          EC    = 20;
    localparam logic [20:0] BOUND = 21'h040000;
    localparam logic [20:0] A0    = 21'h000100;
    localparam logic [20:0] A1    = 21'h100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0, vpp_ok = 1'b1;
    logic [20:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;

    int n_tests = 0;
    int n_fail  = 0;

    int          m_mode [2];
    int          m_pend [2];
    int          m_op   [2];
    int          m_rem  [2];
    bit          m_s3 [2], m_s4 [2], m_s5 [2];
    logic [15:0] m_word [2];

    always #2.5 clk = ~clk;

    flash_cmd_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .vpp_ok(vpp_ok), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            m_mode[k] = 0; m_pend[k] = 0; m_op[k] = 0; m_rem[k] = 0;
            m_s3[k] = 0; m_s4[k] = 0; m_s5[k] = 0; m_word[k] = 16'hFFFF;
        end
    endtask

    function automatic logic [15:0] model_read(input logic [20:0] a);
        int b;
        logic [7:0] s;
        b = (a >= BOUND) ? 1 : 0;
        s = 8'h00;
        if (!(m_op[b] == 1 || m_op[b] == 2)) s[7] = 1'b1;
        if (m_op[b] == 4) s[6] = 1'b1;
        s[5] = m_s5[b];
        s[4] = m_s4[b];
        s[3] = m_s3[b];
        if (m_op[b] == 3) s[2] = 1'b1;
        case (m_mode[b])
            0:       return m_word[b];
            1:       return {8'h00, s};
            2:       return a[0] ? 16'h005A : 16'h00A5;
            default: return 16'h00C3;
        endcase
    endfunction

    task automatic model_edge(input logic w, input logic [20:0] a,
                              input logic [15:0] d, input logic v);
        int b, c;
        bit dn [2];
        bit st [2];
        int ld [2];
        int old [2];
        b = (a >= BOUND) ? 1 : 0;
        c = int'(d[7:0]);
        for (int k = 0; k < 2; k++) begin
            old[k] = m_op[k];
            dn[k]  = (m_op[k] == 1 || m_op[k] == 2) && m_rem[k] == 1;
            st[k]  = 0;
            ld[k]  = 0;
        end
        if (w) begin
            if (old[b] == 1 || old[b] == 2) begin
                if (!dn[b]) begin
                    if (c == 'hB0) begin m_op[b] = (old[b] == 1) ? 3 : 4; m_mode[b] = 1; end
                    else if (c == 'h70) m_mode[b] = 1;
                end
            end else if (m_pend[b] == 1) begin
                m_pend[b] = 0; m_mode[b] = 1;
                if (v) begin st[b] = 1; ld[b] = PC; m_op[b] = 1; m_word[b] = m_word[b] & d; end
                else m_s3[b] = 1;
            end else if (m_pend[b] == 2) begin
                m_pend[b] = 0; m_mode[b] = 1;
                if (c == 'hD0) begin
                    if (v) begin st[b] = 1; ld[b] = EC; m_op[b] = 2; m_word[b] = 16'hFFFF; end
                    else m_s3[b] = 1;
                end else begin m_s4[b] = 1; m_s5[b] = 1; end
            end else if (m_pend[b] == 3) begin
                m_pend[b] = 0;
                if (!(c == 'h01 || c == 'hD0 || c == 'h2F)) begin
                    m_s4[b] = 1; m_s5[b] = 1; m_mode[b] = 1;
                end
            end else begin
                case (c)
                    'h40, 'h10: if (old[b] == 0) m_pend[b] = 1;
                    'h20:       if (old[b] == 0) m_pend[b] = 2;
                    'h50: begin m_s3[b] = 0; m_s4[b] = 0; m_s5[b] = 0; m_mode[b] = 0; end
                    'h60: m_pend[b] = 3;
                    'h70: m_mode[b] = 1;
                    'h90: m_mode[b] = 2;
                    'h98: m_mode[b] = 3;
                    'hFF: m_mode[b] = 0;
                    'hD0: if (old[b] == 3 || old[b] == 4) begin
                        m_op[b] = (old[b] == 3) ? 1 : 2; m_mode[b] = 1;
                    end
                    default: ;
                endcase
            end
        end
        for (int k = 0; k < 2; k++) begin
            if (st[k]) m_rem[k] = ld[k];
            else if (m_rem[k] > 0 && old[k] != 3 && old[k] != 4) m_rem[k] = m_rem[k] - 1;
            if (dn[k]) m_op[k] = 0;
        end
    endtask

    // One clock: drive at the falling edge, advance the model, compare at the next falling edge.
    task automatic step(input logic w, input logic r, input logic [20:0] a,
                        input logic [15:0] d, input logic v, input string tag);
        logic        ev;
        logic [15:0] ed;
        wr_en = w; rd_en = r; addr = a; wdata = d; vpp_ok = v;
        ev = rst_n && r;
        ed = model_read(a);
        if (rst_n) model_edge(w, a, d, v);
        else       model_reset();
        @(posedge clk);
        @(negedge clk);
        n_tests++;
        if (rvalid !== ev || (ev && rdata !== ed)) begin
            n_fail++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     r ? tag : "R14", rvalid, rdata, ev, ed);
        end
    endtask

    task automatic wcmd(input logic [20:0] a, input logic [7:0] c);
        step(1'b1, 1'b0, a, {8'h00, c}, 1'b1, "R14");
    endtask

    task automatic rd(input logic [20:0] a, input string tag);
        step(1'b0, 1'b1, a, 16'h0000, 1'b1, tag);
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        // R1: no read data while reset is held
        for (int i = 0; i < 3; i++) rd(A0, "R1");
        rst_n = 1'b1;
        rd(A0, "R1");
        rd(A1, "R1");

        // R2: status on one bank, the other stays in array mode
        wcmd(A1, 8'h70);
        rd(A1, "R2");
        rd(A0, "R11");

        // R12: identifier and query
        wcmd(A0, 8'h90);
        rd(A0, "R12");
        rd(A0 | 21'h1, "R12");
        wcmd(A0, 8'h98);
        rd(A0, "R12");
        wcmd(A0, 8'hFF);
        rd(A0, "R12");

        // R3: program with 40h, poll until ready, read the programmed word
        wcmd(A0, 8'h40);
        step(1'b1, 1'b0, A0, 16'h12F4, 1'b1, "R3");
        for (int i = 0; i < PC + 2; i++) rd(A0, "R3");
        wcmd(A0, 8'hFF);
        rd(A0, "R3");

        // R3: alternate setup code 10h
        wcmd(A0, 8'h10);
        step(1'b1, 1'b0, A0, 16'hF0FF, 1'b1, "R3");
        for (int i = 0; i < PC + 1; i++) rd(A0, "R3");

        // R10: no voltage, then R9 sticky across mode changes and cleared by 50h
        wcmd(A0, 8'h40);
        step(1'b1, 1'b0, A0, 16'h0000, 1'b0, "R10");
        rd(A0, "R10");
        wcmd(A0, 8'h90);
        wcmd(A0, 8'h70);
        rd(A0, "R9");
        wcmd(A0, 8'h50);
        rd(A0, "R9");

        // R5: erase setup followed by a wrong code
        wcmd(A1, 8'h20);
        wcmd(A1, 8'hFF);
        rd(A1, "R5");
        wcmd(A1, 8'h50);
        rd(A1, "R5");

        // R4: erase on bank 1 with R6, R11, R7, R8 during it
        wcmd(A1, 8'h20);
        wcmd(A1, 8'hD0);
        rd(A1, "R4");
        wcmd(A1, 8'hFF);
        rd(A1, "R6");
        wcmd(A1, 8'h90);
        rd(A1, "R6");
        wcmd(A1, 8'h50);
        rd(A1, "R6");
        wcmd(A0, 8'h90);
        rd(A0, "R11");
        wcmd(A1, 8'hB0);
        for (int i = 0; i < 4; i++) rd(A1, "R7");
        wcmd(A1, 8'hD0);
        for (int i = 0; i < EC; i++) rd(A1, "R8");
        wcmd(A1, 8'hFF);
        rd(A1, "R11");
        wcmd(A0, 8'hFF);
        rd(A0, "R11");

        // R7, R8: program suspend and resume
        wcmd(A0, 8'h40);
        step(1'b1, 1'b0, A0, 16'h00FF, 1'b1, "R3");
        wcmd(A0, 8'hB0);
        rd(A0, "R7");
        rd(A0, "R7");
        wcmd(A0, 8'hD0);
        for (int i = 0; i < PC; i++) rd(A0, "R8");

        // R13: protection setup accepted, then rejected
        wcmd(A0, 8'hFF);
        wcmd(A0, 8'h60);
        wcmd(A0, 8'h01);
        rd(A0, "R13");
        wcmd(A0, 8'h60);
        wcmd(A0, 8'h2F);
        rd(A0, "R13");
        wcmd(A0, 8'h60);
        wcmd(A0, 8'h77);
        rd(A0, "R13");
        wcmd(A0, 8'h50);
        rd(A0, "R13");

        // R14: read while writing returns the state before the write
        step(1'b1, 1'b1, A1, 16'h0070, 1'b1, "R14");
        rd(A1, "R14");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule